// File: doc/BRIEF.md
# NOR flash command sequencer

This block is a synthesizable behavioural model of a small parallel NOR flash with a 16-bit data bus. A host talks to it through one address/data port. A write is a bus command and a read returns one word. Commands are accepted only after a two-write unlock handshake in which both address and data are qualified. A third write then selects the operation: enter or leave identification mode, arm a single-word program, or set up an erase. A set-up erase is followed by a second unlock and a 0x30 write, and that write erases one sector to all-ones.

The address space holds a run of small boot sectors at the bottom, followed by larger main sectors. An erase sweeps the chosen sector one word per clock, and `busy` is high for the whole sweep. What a read returns depends on the pending command: the array contents, a status word whose bit 7 reports that an erase has completed, or identification words. There is no program or erase timing beyond the sweep itself.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the device is in array read mode with status cleared and `busy` low, and every array word reads 0xFFFF.
- R2: The unlock handshake has two writes. The first writes low byte 0xAA to byte address 0xAAAA and the second writes low byte 0x55 to byte address 0x5554. A first or second write with the wrong address or data aborts to array read mode, and a following data write stores nothing.
- R3: The command byte 0xA0, written to 0xAAAA after an unlock, arms program. The next write stores its 16-bit data at word `addr[7:1]`, and the device returns to array read mode.
- R4: The command byte 0x90 written to 0xAAAA after an unlock enters ID mode. There, reads use word index `addr[7:1]`: index 0 returns MANUF_ID, index 1 returns DEV_ID, index 2 returns 0x0000, and any other index returns 0xFFFF. The command byte 0xF0 written to 0xAAAA after an unlock returns to array read.
- R5: While program is armed, while an erase is set up, during a sweep and after a sweep has finished, reads return the status word 0x00r0 with bit 7 = r. Bit r is 0 until the first erase completes and 1 after it.
- R6: The command byte 0x80 written to 0xAAAA after an unlock sets up an erase. A second unlock followed by 0x30 written to any address other than 0xAAAA erases the sector that holds that address to 0xFFFF and then sets status bit 7. Words outside the sector keep their values.
- R7: A word index below BOOT_WORDS×BOOT_COUNT lies in a sector of BOOT_WORDS words. Any other index lies in a sector of MAIN_WORDS words. The sector starts at the index aligned down to its size.
- R8: `busy` is high for exactly as many cycles as the sector has words, starting the cycle after the 0x30 write. Bus writes made while `busy` is high are ignored, including one made in the sweep's final cycle.
- R9: With no unlock in progress, a write of 0xF0 returns the device to array read from the erase-finished state. When program is armed, a write of exactly 0x00F0 cancels the program and stores nothing.
- R10: A 0x30 written after an unlock with no erase set up aborts to array read and erases nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_addr | input | ADDR_W | Byte address; bit 0 is not used for array words |
| bus_wdata | input | DATA_W | Write data; command bytes in bits 7:0 |
| bus_rdata | output | DATA_W | Read word for `bus_addr` in the current view |
| busy | output | 1 | High while an erase sweep is running |

## Verification
Two events can fall in the same cycle: a bus write, and the last word of an erase sweep, which is also when status bit 7 sets and `busy` falls. The bench provokes this by sending an unlock followed by an ID-entry command during a boot-sector sweep, timed so that the command write lands in the sweep's final cycle. The write is judged ignored if the next read returns the status word 0x0080 rather than an ID word, and `busy` must be low in the cycle right after.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [2:0] {
    M_ARRAY   = 3'd0,
    M_ID      = 3'd1,
    M_PROG    = 3'd2,
    M_ESETUP  = 3'd3,
    M_ERASING = 3'd4,
    M_ERASED  = 3'd5
  } mode_t;

  localparam logic [15:0] UNLOCK_A1 = 16'hAAAA;
  localparam logic [15:0] UNLOCK_A2 = 16'h5554;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  OP_ID_IN  = 8'h90;
  localparam logic [7:0]  OP_ID_OUT = 8'hF0;
  localparam logic [7:0]  OP_ESETUP = 8'h80;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_ERASE  = 8'h30;

  // words in the sector holding word index w
  function automatic int unsigned sector_words(int unsigned w, int unsigned bw,
                                               int unsigned bc, int unsigned mw);
    return (w < bw * bc) ? bw : mw;
  endfunction

  // first word of that sector (sizes are powers of two)
  function automatic int unsigned sector_start(int unsigned w, int unsigned len);
    return w & ~(len - 1);
  endfunction

endpackage

// File: rtl/nor_array.sv
module nor_array #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nor_erase_walker.sv
module nor_erase_walker #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          busy,
  output logic          done,
  output logic          we,
  output logic [AW-1:0] waddr
);
  logic [AW-1:0] cur, end_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cur   <= '0;
      end_r <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cur   <= first;
      end_r <= last;
    end else if (busy) begin
      cur <= cur + 1'b1;
      if (cur == end_r) busy <= 1'b0;
    end
  end

  assign done  = busy && (cur == end_r);
  assign we    = busy;
  assign waddr = cur;

  // R8
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && (waddr == $past(waddr) + 1'b1));
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode import nor_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int AW         = 7,
  parameter int BOOT_WORDS = 8,
  parameter int BOOT_COUNT = 4,
  parameter int MAIN_WORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              erase_done,
  output mode_t             mode,
  output logic              ready,
  output logic              prog_we,
  output logic              erase_start,
  output logic [AW-1:0]     erase_first,
  output logic [AW-1:0]     erase_last
);
  logic [1:0]    phase, phase_n;
  mode_t         mode_n;
  logic [AW-1:0] widx;
  logic [7:0]    cmd;
  logic          hit_a1, hit_a2;
  int unsigned   len, base;

  assign widx   = addr[AW:1];
  assign cmd    = wdata[7:0];
  assign hit_a1 = (addr == ADDR_W'(UNLOCK_A1));
  assign hit_a2 = (addr == ADDR_W'(UNLOCK_A2));

  always_comb begin
    len         = sector_words(int'(widx), BOOT_WORDS, BOOT_COUNT, MAIN_WORDS);
    base        = sector_start(int'(widx), len);
    erase_first = AW'(base);
    erase_last  = AW'(base + len - 1);
  end

  always_comb begin
    phase_n     = phase;
    mode_n      = mode;
    prog_we     = 1'b0;
    erase_start = 1'b0;
    if (erase_done) mode_n = M_ERASED;
    if (wr_ok) begin
      unique case (phase)
        2'd0: begin
          if (mode == M_PROG) begin
            prog_we = (wdata != DATA_W'(16'h00F0));
            mode_n  = M_ARRAY;
          end else if (cmd == KEY_1 && hit_a1) begin
            phase_n = 2'd1;
          end else begin
            mode_n = M_ARRAY;
          end
        end
        2'd1: begin
          if (cmd == KEY_2 && hit_a2) phase_n = 2'd2;
          else begin
            phase_n = 2'd0;
            mode_n  = M_ARRAY;
          end
        end
        default: begin
          phase_n = 2'd0;
          if (hit_a1) begin
            unique case (cmd)
              OP_ID_IN:  mode_n = M_ID;
              OP_ESETUP: mode_n = M_ESETUP;
              OP_PROG:   mode_n = M_PROG;
              default:   mode_n = M_ARRAY;
            endcase
          end else if (cmd == OP_ERASE && mode == M_ESETUP) begin
            erase_start = 1'b1;
            mode_n      = M_ERASING;
          end else begin
            mode_n = M_ARRAY;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 2'd0;
      mode  <= M_ARRAY;
      ready <= 1'b0;
    end else begin
      phase <= phase_n;
      mode  <= mode_n;
      if (erase_done) ready <= 1'b1;
    end
  end

  // R3
  prog_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> mode == M_ARRAY);
  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> ready && mode == M_ERASED);
  // R2
  phase_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && phase == 2'd1 && !hit_a2 |=> phase == 2'd0 && mode == M_ARRAY);
  // R6
  erase_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> mode == M_ERASING);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq import nor_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int BOOT_WORDS = 8,
  parameter int BOOT_COUNT = 4,
  parameter int MAIN_WORDS = 32,
  parameter int MAIN_COUNT = 3,
  parameter logic [DATA_W-1:0] MANUF_ID = 16'h0037,
  parameter logic [DATA_W-1:0] DEV_ID   = 16'h00A5,
  localparam int DEPTH = BOOT_WORDS * BOOT_COUNT + MAIN_WORDS * MAIN_COUNT,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy
);
  mode_t             mode;
  logic              ready, prog_we, erase_start, erase_done, walk_we, wr_ok;
  logic [AW-1:0]     erase_first, erase_last, walk_addr, arr_waddr;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;
  logic [6:0]        id_idx;

  assign wr_ok = bus_wr && !busy;

  nor_cmd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AW(AW),
    .BOOT_WORDS(BOOT_WORDS), .BOOT_COUNT(BOOT_COUNT), .MAIN_WORDS(MAIN_WORDS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .erase_done(erase_done), .mode(mode), .ready(ready), .prog_we(prog_we),
    .erase_start(erase_start), .erase_first(erase_first), .erase_last(erase_last)
  );

  nor_erase_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(erase_start), .first(erase_first),
    .last(erase_last), .busy(busy), .done(erase_done), .we(walk_we),
    .waddr(walk_addr)
  );

  assign arr_waddr = walk_we ? walk_addr : bus_addr[AW:1];
  assign arr_wdata = walk_we ? '1 : bus_wdata;

  nor_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(walk_we || prog_we), .waddr(arr_waddr),
    .wdata(arr_wdata), .raddr(bus_addr[AW:1]), .rdata(arr_rdata)
  );

  assign id_idx = bus_addr[7:1];

  always_comb begin
    unique case (mode)
      M_ARRAY: bus_rdata = arr_rdata;
      M_ID: begin
        unique case (id_idx)
          7'd0:    bus_rdata = MANUF_ID;
          7'd1:    bus_rdata = DEV_ID;
          7'd2:    bus_rdata = '0;
          default: bus_rdata = '1;
        endcase
      end
      default: bus_rdata = DATA_W'({ready, 7'b0});
    endcase
  end

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_we && walk_we));
  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr |=> !prog_we || !$past(busy));
endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam logic [15:0] MID = 16'h0037;
  localparam logic [15:0] DID = 16'h00A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        busy;

  always #5 clk = ~clk;

  nor_cmd_seq u_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  typedef struct {
    bit          is_busy;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t it;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // monitor: compares at the falling edge of the cycle the item was pushed
  always @(negedge clk) begin
    if (q.size() > 0) begin
      it = q.pop_front();
      n_chk++;
      if (it.is_busy) begin
        if (busy !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s busy actual=%b expected=%b", it.tag, busy, it.exp[0]);
        end
      end else if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string tag);
    item_t x;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = a;
    x.is_busy = 1'b1; x.is_busy = 1'b0; x.exp = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic chk_busy(input logic b, input string tag);
    item_t x;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    x.is_busy = 1'b1; x.exp = {15'd0, b}; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic unlock();
    wr(16'hAAAA, 16'h00AA);
    wr(16'h5554, 16'h0055);
  endtask

  task automatic cmd(input logic [7:0] c);
    unlock();
    wr(16'hAAAA, {8'h00, c});
  endtask

  task automatic prog(input int w, input logic [15:0] d);
    cmd(8'hA0);
    wr(16'(w * 2), d);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_busy(1'b0, "R1");
    rd(16'h000A, 16'hFFFF, "R1");
    rd(16'h00FE, 16'hFFFF, "R1");

    // R3 and R5 program
    cmd(8'hA0);
    rd(16'h0000, 16'h0000, "R5 prog armed");
    wr(16'h000A, 16'h1234);
    rd(16'h000A, 16'h1234, "R3");
    prog(7, 16'h0707);  prog(8, 16'h0808);
    prog(15, 16'h1515); prog(16, 16'h1616);
    prog(63, 16'h6363); prog(64, 16'h6464);
    prog(95, 16'h9595); prog(96, 16'h9696);
    rd(16'(16 * 2), 16'h1616, "R3");
    rd(16'(96 * 2), 16'h9696, "R3");

    // R4 ID mode
    cmd(8'h90);
    rd(16'h0000, MID, "R4 manuf");
    rd(16'h0002, DID, "R4 device");
    rd(16'h0004, 16'h0000, "R4 protect");
    rd(16'h0006, 16'hFFFF, "R4 other");
    cmd(8'hF0);
    rd(16'h000A, 16'h1234, "R4 exit");

    // R2 wrong second address
    wr(16'hAAAA, 16'h00AA);
    wr(16'h5555, 16'h0055);
    wr(16'hAAAA, 16'h00A0);
    wr(16'h000A, 16'hBEEF);
    rd(16'h000A, 16'h1234, "R2 bad addr");
    // R2 wrong first data
    wr(16'hAAAA, 16'h00AB);
    wr(16'h5554, 16'h0055);
    wr(16'hAAAA, 16'h00A0);
    wr(16'h000A, 16'hBEEF);
    rd(16'h000A, 16'h1234, "R2 bad data");

    // R10 erase without set-up
    unlock();
    wr(16'h0016, 16'h0030);
    chk_busy(1'b0, "R10");
    rd(16'h0010, 16'h0808, "R10");

    // R9 program cancel
    cmd(8'hA0);
    wr(16'h000A, 16'h00F0);
    rd(16'h000A, 16'h1234, "R9 cancel");

    // R6 R7 R8 boot sector erase at word 11, ID entry colliding with sweep end
    cmd(8'h80);
    rd(16'h0000, 16'h0000, "R5 setup");
    unlock();
    wr(16'h0016, 16'h0030);
    for (int i = 0; i < 5; i++) chk_busy(1'b1, "R8 boot");
    cmd(8'h90);
    chk_busy(1'b0, "R8 boot end");
    rd(16'h0000, 16'h0080, "R8 ignored write");
    wr(16'h0000, 16'h00F0);
    rd(16'h0010, 16'hFFFF, "R6 boot");
    rd(16'h001E, 16'hFFFF, "R7 boot top");
    rd(16'h000E, 16'h0707, "R7 below");
    rd(16'h0020, 16'h1616, "R7 above");
    rd(16'h000A, 16'h1234, "R6 untouched");

    // R7 R8 main sector erase at word 70
    cmd(8'h80);
    rd(16'h0000, 16'h0080, "R5 ready kept");
    unlock();
    wr(16'h008C, 16'h0030);
    for (int i = 0; i < 32; i++) chk_busy(1'b1, "R8 main");
    chk_busy(1'b0, "R8 main end");
    rd(16'h0000, 16'h0080, "R5 erased");
    wr(16'h0000, 16'h00F0);
    rd(16'(64 * 2), 16'hFFFF, "R7 main first");
    rd(16'(95 * 2), 16'hFFFF, "R7 main last");
    rd(16'(63 * 2), 16'h6363, "R7 main below");
    rd(16'(96 * 2), 16'h9696, "R7 main above");

    chk_busy(1'b0, "R9 idle");
    @(posedge clk); #1;
    done = 1'b1;
    report();
    $finish;
  end
endmodule